// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal by counting its rising edges over a gate window of known length. The gate window is timed from a slow crystal reference. Software arms a measurement by raising a start bit and chooses one of four window lengths with a 2-bit code. Every measurement first spends a fixed settling wait, during which edges are ignored. The gate window then opens. When it closes, the block holds the count and raises a done flag. Lowering the start bit clears the count and the flag.

The crystal reference arrives as a one-cycle enable pulse, `xtal_tick`, on the system clock. Both the wait timer and the gate timer advance only on that pulse. While the synthesizer is inhibited, every timer and the counter stand still. A shared open-drain status pin can be set to report completion. It is pulled low once a measurement has finished, and it is released as soon as a new measurement is armed.

Top module: `if_freq_counter`

## Requirements
- R1: After reset the count is 0, the done flag is 0 and the status pin is released (`do_low_o` = 0).
- R2: Whenever `start` is 0, the count and the done flag are 0 from the next clock on.
- R3: A 0-to-1 change of `start` opens a settling wait of WAIT_TICKS (263) crystal ticks. IF edges during the wait are not counted.
- R4: After the wait, the gate stays open for GATE_BASE shifted left by the code in crystal ticks. With `gate_sel` = 0, 1, 2 and 3 this gives 300, 600, 1200 and 2400 ticks. When the gate closes, `done_o` rises.
- R5: Each rising edge of `if_in` that is sampled while the gate is open adds one to the count. Once done, the count holds until `start` falls or rises again.
- R6: The count saturates at all ones (2^CNT_W − 1) and does not wrap.
- R7: A change of `gate_sel` after the start edge does not change the length of the running measurement.
- R8: While `pll_inhibit` is 1, the wait timer, the gate timer and the counter all hold. IF edges in that time are lost, and the measurement ends later by the length of the inhibit.
- R9: With `end_mode` = 1, `do_low_o` is 1 exactly while a finished measurement is held. The pin is released in the cycle after a new start edge. With `end_mode` = 0 it stays released.
- R10: Timers advance only in cycles where `xtal_tick` is 1. With a tick every second clock, a measurement takes about twice as many clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_tick | input | 1 | One-cycle crystal reference enable |
| if_in | input | 1 | IF signal, already synchronous to clk |
| start | input | 1 | Measurement arm; its rising edge starts, its low level clears |
| gate_sel | input | 2 | Gate length code, captured at the start edge |
| pll_inhibit | input | 1 | Freezes timers and counter while high |
| end_mode | input | 1 | Routes completion to the status pin |
| count_o | output | CNT_W | Held edge count |
| done_o | output | 1 | Measurement finished |
| do_low_o | output | 1 | 1 = pull the open-drain status pin low |

## Verification
A vector table runs every gate code at a full tick rate, and one code at half tick rate. Each run sends a chosen number of IF pulses well inside the gate and a burst inside the wait. An exact count then separates counting in the gate from counting in the wait, and the clock count to done separates each gate length and the tick dependence. Directed runs cover the remaining behaviour:
- a gate code changed in mid-measurement, where a timing shift would expose R7;
- an inhibit interval with pulses inside it, where both the lost pulses and the delay are checked;
- a continuously toggling IF on a narrow-counter instance, which shows saturation;
- the arm/clear sequence, which shows the status pin being driven and released.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_GATE = 2'd2,
        PH_DONE = 2'd3
    } phase_t;

    // Gate length in crystal ticks: base doubled once per code step.
    function automatic int unsigned gate_ticks(input logic [1:0] code,
                                               input int unsigned base);
        return base << code;
    endfunction

endpackage

// File: rtl/ifc_rise.sv
module ifc_rise (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
endmodule

// File: rtl/ifc_timer.sv
module ifc_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          advance,
    input  logic [TW-1:0] limit,
    output logic          hit
);
    logic [TW-1:0] cnt;

    assign hit = advance && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clear || hit) cnt <= '0;
        else if (advance)        cnt <= cnt + 1'b1;
    end

    // R4
    timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
        advance |-> (cnt < limit));
endmodule

// File: rtl/ifc_accum.sv
module ifc_accum #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clear)             count <= '0;
        else if (inc && count != TOP) count <= count + 1'b1;
    end

    // R6
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (count == TOP && !clear) |=> (count == TOP));
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear && !inc) |=> $stable(count));
endmodule

// File: rtl/if_freq_counter.sv
module if_freq_counter
    import ifc_pkg::*;
#(
    parameter int CNT_W      = 20,
    parameter int WAIT_TICKS = 263,
    parameter int GATE_BASE  = 300
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xtal_tick,
    input  logic             if_in,
    input  logic             start,
    input  logic [1:0]       gate_sel,
    input  logic             pll_inhibit,
    input  logic             end_mode,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o,
    output logic             do_low_o
);
    localparam int MAX_T = (GATE_BASE * 8 > WAIT_TICKS) ? GATE_BASE * 8 : WAIT_TICKS;
    localparam int TW    = $clog2(MAX_T + 1);

    phase_t        phase;
    logic [1:0]    sel_q;
    logic          start_rise;
    logic          if_rise;
    logic          tmr_hit;
    logic          tmr_adv;
    logic          tmr_clr;
    logic [TW-1:0] tmr_limit;
    logic          acc_clr;
    logic          acc_inc;

    ifc_rise u_start_edge (.clk(clk), .rst(rst), .sig(start), .rise(start_rise));
    ifc_rise u_if_edge    (.clk(clk), .rst(rst), .sig(if_in), .rise(if_rise));

    assign tmr_adv   = xtal_tick && !pll_inhibit && start && !start_rise &&
                       (phase == PH_WAIT || phase == PH_GATE);
    assign tmr_clr   = !start || start_rise;
    assign tmr_limit = (phase == PH_WAIT) ? TW'(WAIT_TICKS)
                                          : TW'(gate_ticks(sel_q, GATE_BASE));

    ifc_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .clear(tmr_clr), .advance(tmr_adv),
        .limit(tmr_limit), .hit(tmr_hit)
    );

    assign acc_clr = !start || start_rise;
    assign acc_inc = (phase == PH_GATE) && if_rise && !pll_inhibit;

    ifc_accum #(.W(CNT_W)) u_accum (
        .clk(clk), .rst(rst), .clear(acc_clr), .inc(acc_inc), .count(count_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            sel_q <= 2'd0;
        end else if (!start) begin
            phase <= PH_IDLE;
        end else if (start_rise) begin
            phase <= PH_WAIT;
            sel_q <= gate_sel;
        end else if (tmr_hit) begin
            if (phase == PH_WAIT)      phase <= PH_GATE;
            else if (phase == PH_GATE) phase <= PH_DONE;
        end
    end

    assign done_o   = (phase == PH_DONE);
    assign do_low_o = end_mode && done_o;

    // R2
    stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> (count_o == '0 && !done_o));
    // R9
    rearm_release_chk: assert property (@(posedge clk) disable iff (rst)
        start_rise |=> !do_low_o);
    // R8
    inhibit_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (pll_inhibit && start && !start_rise) |=> ($stable(count_o) && $stable(phase)));
    // R3
    wait_no_count_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT) |-> (count_o == '0));
    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !start_rise) |=> $stable(sel_q));
endmodule

// File: tb/tb_if_freq_counter.sv
module tb_if_freq_counter;
    localparam int W_TICKS = 263;
    localparam int G_BASE  = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic xtal_tick = 1'b0, if_in = 1'b0, start = 1'b0;
    logic [1:0] gate_sel = 2'd0;
    logic pll_inhibit = 1'b0, end_mode = 1'b0;
    logic [19:0] count_o;
    logic done_o, do_low_o;
    logic [5:0] s_count;
    logic s_done, s_do;

    int checks = 0;
    int errors = 0;
    int meas_n;
    int meas_cnt;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    if_freq_counter dut (
        .clk(clk), .rst(rst), .xtal_tick(xtal_tick), .if_in(if_in), .start(start),
        .gate_sel(gate_sel), .pll_inhibit(pll_inhibit), .end_mode(end_mode),
        .count_o(count_o), .done_o(done_o), .do_low_o(do_low_o)
    );

    if_freq_counter #(.CNT_W(6), .WAIT_TICKS(8), .GATE_BASE(100)) dut_small (
        .clk(clk), .rst(rst), .xtal_tick(xtal_tick), .if_in(if_in), .start(start),
        .gate_sel(gate_sel), .pll_inhibit(pll_inhibit), .end_mode(end_mode),
        .count_o(s_count), .done_o(s_done), .do_low_o(s_do)
    );

    // columns: gate code, tick divisor, pulses in gate
    localparam int NV = 5;
    localparam int VEC [NV][3] = '{
        '{0, 1, 7},
        '{1, 1, 40},
        '{2, 1, 0},
        '{3, 1, 100},
        '{0, 2, 25}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_meas(input int sel, input int div, input int m,
                            input int inh_at, input int inh_len,
                            input int chg_at, input bit fill);
        int g0;
        bit seen;
        g0 = (W_TICKS + 10) * div;
        seen = 1'b0;
        @(negedge clk);
        gate_sel  = 2'(sel);
        start     = 1'b1;
        xtal_tick = (div == 1);
        for (int i = 1; i < 30000; i++) begin
            @(negedge clk);
            xtal_tick   = ((i % div) == 0);
            pll_inhibit = (i >= inh_at) && (i < inh_at + inh_len);
            if (fill)                                  if_in = i[0];
            else if (i >= 20 && i < 30)                if_in = i[0];
            else if (i >= g0 && i < g0 + 2 * m)        if_in = ((i - g0) % 2 == 0);
            else if (pll_inhibit)                      if_in = i[0];
            else                                       if_in = 1'b0;
            if (i == chg_at) gate_sel = ~gate_sel;
            if (done_o) begin
                meas_n = i;
                seen   = 1'b1;
                break;
            end
        end
        if_in = 1'b0;
        pll_inhibit = 1'b0;
        xtal_tick = 1'b1;
        meas_cnt = int'(count_o);
        if (!seen) chk(1'b0, "R4 done never seen", 0, 1);
    endtask

    task automatic stop_meas();
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(count_o == 0, "R1 count", int'(count_o), 0);
        chk(!done_o && !do_low_o, "R1 done/pin", int'({done_o, do_low_o}), 0);

        // vector table: R3 R4 R5 R10
        for (int v = 0; v < NV; v++) begin
            int expn;
            run_meas(VEC[v][0], VEC[v][1], VEC[v][2], 0, 0, -1, 1'b0);
            expn = (W_TICKS + (G_BASE << VEC[v][0])) * VEC[v][1] + 1;
            chk(meas_cnt == VEC[v][2], "R5/R3 count", meas_cnt, VEC[v][2]);
            if (VEC[v][1] == 1)
                chk(meas_n == expn, "R4 gate length", meas_n, expn);
            else
                chk(meas_n >= expn - 2 && meas_n <= expn + 2, "R10 tick rate", meas_n, expn);
            stop_meas();
        end

        // R5 count held after done while IF keeps toggling
        run_meas(1, 1, 12, 0, 0, -1, 1'b0);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if_in = k[0];
        end
        chk(count_o == 12, "R5 hold after done", int'(count_o), 12);
        stop_meas();

        // R7 gate code change mid-measurement
        run_meas(0, 1, 5, 0, 0, 100, 1'b0);
        chk(meas_n == W_TICKS + G_BASE + 1, "R7 gate code ignored", meas_n, W_TICKS + G_BASE + 1);
        stop_meas();

        // R8 inhibit freezes timers and counting
        run_meas(0, 1, 10, 300, 50, -1, 1'b0);
        chk(meas_cnt == 10, "R8 pulses lost", meas_cnt, 10);
        chk(meas_n == W_TICKS + G_BASE + 51, "R8 delay", meas_n, W_TICKS + G_BASE + 51);
        stop_meas();

        // R6 saturation on the narrow instance
        run_meas(1, 1, 0, 0, 0, -1, 1'b1);
        chk(s_done, "R6 small done", int'(s_done), 1);
        chk(s_count == 6'h3F, "R6 saturate", int'(s_count), 63);

        // R9 pin follows end_mode with a held result
        chk(!do_low_o, "R9 pin released when end_mode=0", int'(do_low_o), 0);
        end_mode = 1'b1;
        @(negedge clk);
        chk(do_low_o, "R9 pin low when done", int'(do_low_o), 1);
        // R2 start low clears
        start = 1'b0;
        @(negedge clk);
        chk(count_o == 0 && !done_o, "R2 clear", int'(count_o), 0);
        chk(!do_low_o, "R9 pin released on clear", int'(do_low_o), 0);
        start = 1'b1;
        @(negedge clk);
        chk(!do_low_o && !done_o, "R9 released after re-arm", int'(do_low_o), 0);
        run_meas(0, 1, 3, 0, 0, -1, 1'b0);
        chk(do_low_o, "R9 pin low at completion", int'(do_low_o), 1);
        chk(meas_cnt == 3, "R5 re-armed count", meas_cnt, 3);
        stop_meas();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #750000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule